// File: doc/BRIEF.md
# Pipelined Unsigned Array Multiplier

This block multiplies two unsigned operands of `WIDTH` bits each and returns the full product of `2*WIDTH` bits. The multiplier is a regular grid of gated adder cells. Each cell takes one bit of the multiplicand, one bit of the running sum, one multiplier bit and a carry. When its multiplier bit is set, the cell adds the multiplicand bit and the carry to the running-sum bit. When the multiplier bit is clear, it adds only the carry to the running-sum bit. There is one row of cells for each multiplier bit. The first row starts from a sum of zero, and the carry into every row is zero.

The rows are split into pipeline stages of `ROWS_PER_STAGE` rows each, with a register bank after every stage. The operands travel alongside the partial sum, so each row works on the operands of its own product. Each row also settles one low product bit early. That bit is held in the stage registers until the top half of the product is complete. A valid flag runs beside the data, so a new operand pair can be accepted on every clock.

The reset input is asynchronous and active low. It clears the valid flags at once, and its release is synchronised inside the block.

Top module: `pipe_array_mult`

## Requirements
- R1: When `out_valid` is high, `out_p` equals the full unsigned product `in_a * in_b` (2*WIDTH bits) of the operand pair whose `in_valid` produced it.
- R2: `out_valid` rises exactly LATENCY clock edges after the edge that captured `in_valid`. LATENCY = ceil(WIDTH / ROWS_PER_STAGE), which is 4 with the defaults (WIDTH 8, 2 rows per stage).
- R3: Operand pairs presented on consecutive cycles each produce their own correct product on consecutive output cycles. No value leaks from one pair into its neighbour.
- R4: While `rst_n` is low, `out_valid` is low with no clock needed. After `rst_n` rises, `out_valid` stays low until a new pair has completed the pipeline. Every pair that was in flight when reset arrived is dropped. Inputs are taken again from the third rising clock edge after `rst_n` is released.
- R5: A cycle with `in_valid` low produces a cycle with `out_valid` low exactly LATENCY cycles later, so gaps in the input stream keep their positions at the output.
- R6: Operands at the edges of the range give exact results: a zero operand gives 0, an operand of one gives the other operand, and all-ones times all-ones gives (2^WIDTH-1)^2, which is 16'hFE01 for WIDTH 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Marks `in_a` and `in_b` as a pair to multiply in this cycle |
| in_a | input | WIDTH | Unsigned multiplicand |
| in_b | input | WIDTH | Unsigned multiplier |
| out_valid | output | 1 | Marks `out_p` as a finished product |
| out_p | output | 2*WIDTH | Unsigned product |

## Verification
Some properties are checked on every clock. Each stage's valid flag must follow its input valid one edge later, for both the high and the low case. After every stage, the registered partial sum and early low bits must equal the multiplicand times the multiplier bits consumed so far. The final product must match the operands that travelled alongside it. These checks cannot tell whether the product appears in the right cycle relative to the input stream. They also cannot see the reset-release delay, or whether pairs in flight are dropped by a reset. Only the bench's scenarios show those. The bench drives an exhaustive sweep of all operand pairs, back-to-back and gapped streams, edge operands, and a reset in the middle of a stream.

// File: rtl/mulpipe_pkg.sv
package mulpipe_pkg;

  // integer ceiling division used for stage counts
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // number of rows handled by a stage starting at row first
  function automatic int rows_in_stage(input int width, input int rps, input int first);
    return ((width - first) < rps) ? (width - first) : rps;
  endfunction

endpackage

// File: rtl/mulpipe_cell.sv
module mulpipe_cell (
  input  logic x,     // multiplicand bit
  input  logic y,     // running-sum bit
  input  logic z,     // multiplier bit selecting the addend
  input  logic cin,
  output logic s,
  output logic cout
);

  logic addend;

  always_comb begin
    addend = x & z;
    s      = addend ^ y ^ cin;
    cout   = (addend & y) | (addend & cin) | (y & cin);
  end

endmodule

// File: rtl/mulpipe_row.sv
module mulpipe_row #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] mcand,
  input  logic [WIDTH-1:0] sum_in,
  input  logic             zbit,
  output logic [WIDTH-1:0] sum_out,
  output logic             prod_bit
);

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] cell_s;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    mulpipe_cell u_cell (
      .x    (mcand[i]),
      .y    (sum_in[i]),
      .z    (zbit),
      .cin  (carry[i]),
      .s    (cell_s[i]),
      .cout (carry[i+1])
    );
  end

  // lowest bit is final; the rest shifts down as the next running sum
  always_comb begin
    prod_bit = cell_s[0];
    sum_out  = {carry[WIDTH], cell_s[WIDTH-1:1]};
  end

endmodule

// File: rtl/mulpipe_stage.sv
module mulpipe_stage #(
  parameter int WIDTH = 8,
  parameter int FIRST = 0,
  parameter int NROWS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] psum_i,
  input  logic [WIDTH-1:0] low_i,
  output logic             vld_o,
  output logic [WIDTH-1:0] a_o,
  output logic [WIDTH-1:0] b_o,
  output logic [WIDTH-1:0] psum_o,
  output logic [WIDTH-1:0] low_o
);

  localparam int DONE = FIRST + NROWS;
  localparam int PW   = 2 * WIDTH;

  logic [WIDTH-1:0] chain [NROWS+1];
  logic [NROWS-1:0] pbit;

  logic             vld_n;
  logic [WIDTH-1:0] a_n, b_n, psum_n, low_n;
  logic             vld_q;
  logic [WIDTH-1:0] a_q, b_q, psum_q, low_q;

  assign chain[0] = psum_i;

  for (genvar r = 0; r < NROWS; r++) begin : g_row
    mulpipe_row #(.WIDTH(WIDTH)) u_row (
      .mcand    (a_i),
      .sum_in   (chain[r]),
      .zbit     (b_i[FIRST+r]),
      .sum_out  (chain[r+1]),
      .prod_bit (pbit[r])
    );
  end

  // next-state
  always_comb begin
    vld_n  = vld_i;
    a_n    = a_i;
    b_n    = b_i;
    psum_n = chain[NROWS];
    low_n  = low_i;
    for (int r = 0; r < NROWS; r++) begin
      low_n[FIRST+r] = pbit[r];
    end
  end

  // valid flag: reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_n;
  end

  // data: no reset, loaded only with a valid pair
  always_ff @(posedge clk) begin
    if (vld_i) begin
      a_q    <= a_n;
      b_q    <= b_n;
      psum_q <= psum_n;
      low_q  <= low_n;
    end
  end

  assign vld_o  = vld_q;
  assign a_o    = a_q;
  assign b_o    = b_q;
  assign psum_o = psum_q;
  assign low_o  = low_q;

  // checker values: partial product over the rows consumed so far
  logic [WIDTH-1:0] done_mask;
  logic [PW-1:0]    chk_held, chk_ref;

  always_comb begin
    done_mask = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (i < DONE) done_mask[i] = 1'b1;
    end
    chk_held = ({{WIDTH{1'b0}}, psum_q} << DONE) | {{WIDTH{1'b0}}, low_q & done_mask};
    chk_ref  = {{WIDTH{1'b0}}, a_q} * {{WIDTH{1'b0}}, b_q & done_mask};
  end

  // R2
  vld_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> vld_o);

  // R5
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> !vld_o);

  // R1
  stage_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (chk_held == chk_ref));

endmodule

// File: rtl/mulpipe_rst_sync.sv
module mulpipe_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [1:0] sync_q;
  logic [1:0] sync_n;

  always_comb sync_n = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= 2'b00;
    else              sync_q <= sync_n;
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/pipe_array_mult.sv
module pipe_array_mult #(
  parameter int WIDTH          = 8,
  parameter int ROWS_PER_STAGE = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [WIDTH-1:0]   in_a,
  input  logic [WIDTH-1:0]   in_b,
  output logic               out_valid,
  output logic [2*WIDTH-1:0] out_p
);

  import mulpipe_pkg::*;

  localparam int NSTG    = ceil_div(WIDTH, ROWS_PER_STAGE);
  localparam int LATENCY = NSTG;
  localparam int PW      = 2 * WIDTH;

  logic rst_n_s;

  mulpipe_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  logic             vld  [NSTG+1];
  logic [WIDTH-1:0] opa  [NSTG+1];
  logic [WIDTH-1:0] opb  [NSTG+1];
  logic [WIDTH-1:0] psum [NSTG+1];
  logic [WIDTH-1:0] low  [NSTG+1];

  // first row: zero running sum, no low bits yet
  always_comb begin
    vld[0]  = in_valid;
    opa[0]  = in_a;
    opb[0]  = in_b;
    psum[0] = '0;
    low[0]  = '0;
  end

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    localparam int FIRST = s * ROWS_PER_STAGE;
    localparam int NR    = rows_in_stage(WIDTH, ROWS_PER_STAGE, FIRST);
    mulpipe_stage #(
      .WIDTH (WIDTH),
      .FIRST (FIRST),
      .NROWS (NR)
    ) u_stage (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .vld_i  (vld[s]),
      .a_i    (opa[s]),
      .b_i    (opb[s]),
      .psum_i (psum[s]),
      .low_i  (low[s]),
      .vld_o  (vld[s+1]),
      .a_o    (opa[s+1]),
      .b_o    (opb[s+1]),
      .psum_o (psum[s+1]),
      .low_o  (low[s+1])
    );
  end

  assign out_valid = vld[NSTG];
  assign out_p     = {psum[NSTG], low[NSTG]};

  // R1
  final_prod_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    out_valid |-> (out_p == PW'({{WIDTH{1'b0}}, opa[NSTG]} * {{WIDTH{1'b0}}, opb[NSTG]})));

  // R4
  always_comb begin
    if (!rst_n) begin
      rst_clears_chk: assert (!out_valid || ($time == 0));
    end
  end

  // latency parameter kept visible for integration
  initial begin
    latency_param_chk: assert (LATENCY >= 1);
  end

endmodule

// File: tb/pipe_array_mult_test.sv
module pipe_array_mult_test;

  localparam int CLK_PERIOD = 10;
  localparam int W   = 8;
  localparam int RPS = 2;
  localparam int LAT = (W + RPS - 1) / RPS;
  localparam int PW  = 2 * W;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [W-1:0]  in_a, in_b;
  logic          out_valid;
  logic [PW-1:0] out_p;

  pipe_array_mult #(.WIDTH(W), .ROWS_PER_STAGE(RPS)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_p     (out_p)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;

  // bench's own record of what was sent LAT cycles ago
  logic         rv [LAT];
  logic [W-1:0] ra [LAT];
  logic [W-1:0] rb [LAT];
  int           rp = 0;
  logic [15:0]  lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_ring();
    for (int i = 0; i < LAT; i++) begin
      rv[i] = 1'b0; ra[i] = '0; rb[i] = '0;
    end
  endtask

  function automatic logic [W-1:0] next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[W-1:0];
  endfunction

  // one cycle: check output due now, then drive the next input
  task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                      input string req);
    logic [PW-1:0] exp;
    @(negedge clk);
    check(out_valid == rv[rp], req, "out_valid", PW'(out_valid), PW'(rv[rp]));
    if (rv[rp]) begin
      exp = {{W{1'b0}}, ra[rp]} * {{W{1'b0}}, rb[rp]};
      check(out_p == exp, req, "out_p", out_p, exp);
    end
    rv[rp] = v; ra[rp] = a; rb[rp] = b;
    rp = (rp + 1) % LAT;
    in_valid = v; in_a = a; in_b = b;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < LAT + 1; i++) step(1'b0, '0, '0, req);
  endtask

  // R4: reset state and release
  task automatic t_reset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R4", "out_valid in reset", PW'(out_valid), '0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, '0, '0, "R4");
  endtask

  // R6: edge operands, back to back
  task automatic t_corners();
    step(1'b1, 8'd0,   8'd173, "R6");
    step(1'b1, 8'd91,  8'd0,   "R6");
    step(1'b1, 8'd1,   8'd222, "R6");
    step(1'b1, 8'd147, 8'd1,   "R6");
    step(1'b1, 8'hFF,  8'hFF,  "R6");
    step(1'b1, 8'hFF,  8'd1,   "R6");
    step(1'b1, 8'h80,  8'h80,  "R6");
    drain("R6");
  endtask

  // R3: dense pseudo-random stream
  task automatic t_stream();
    for (int i = 0; i < 64; i++) step(1'b1, next_rand(), next_rand(), "R3");
    drain("R3");
  endtask

  // R2 and R5: isolated pulse, then gapped stream
  task automatic t_gaps();
    step(1'b1, 8'd13, 8'd11, "R2");
    for (int i = 0; i < LAT + 2; i++) step(1'b0, 8'hFF, 8'hFF, "R2");
    for (int i = 0; i < 48; i++) begin
      if ((i % 3) == 0) step(1'b0, next_rand(), next_rand(), "R5");
      else              step(1'b1, next_rand(), next_rand(), "R5");
    end
    drain("R5");
  endtask

  // R4: reset in mid-stream drops everything in flight
  task automatic t_mid_reset();
    for (int i = 0; i < LAT - 1; i++) step(1'b1, next_rand(), next_rand(), "R4");
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    #1;
    check(out_valid == 1'b0, "R4", "out_valid at reset assert", PW'(out_valid), '0);
    clear_ring();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < LAT + 3; i++) step(1'b0, '0, '0, "R4");
  endtask

  // R1: every operand pair
  task automatic t_exhaustive();
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        step(1'b1, W'(a), W'(b), "R1");
      end
    end
    drain("R1");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_a     = '0;
    in_b     = '0;
    clear_ring();
    t_reset();
    t_corners();
    t_stream();
    t_gaps();
    t_mid_reset();
    t_exhaustive();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule